// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins behind a word-wide register bus. Each pin can be an input or an output. A per-pin access mask decides whether software can use the pin at all. A separate input-enable bit decides whether the sampled pad value is seen. Pad inputs pass through a two-flop synchronizer. The block drives the pad outputs and output enables, and it raises a single interrupt line.

Each pin has its own trigger type. It can detect a high or low level, or a rising or falling edge, or both edges. A level trigger follows the pin as long as the level is present. An edge trigger is latched until software writes a 1 to that pin's clear bit. Raw and masked status can both be read. The interrupt line is the OR of the masked status bits.

Registers sit at fixed word offsets inside a 0x80-byte window. Writes take effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: `pad_oe` bit i is 1 exactly when the direction bit (offset 0x08, 1 = output) and the access-mask bit (offset 0x04) of pin i are both 1. `pad_out` is the output data gated by `pad_oe`.
- R3: A write to the data register (offset 0x00) changes only the bits whose access-mask bit is 1.
- R4: Reading the data register returns, for each pin whose mask bit is 1, the stored output value if the direction bit is 1. If the direction bit is 0, it returns the synchronized pad value ANDed with the input-enable bit (offset 0x28). Unmasked pins read 0.
- R5: With the sense bit (offset 0x0C) at 1, raw status (offset 0x1C) follows the qualified pin level. Polarity bit 1 (offset 0x14) means active high and 0 means active low. The level is not latched.
- R6: With the sense bit at 0 and the both-edges bit (offset 0x10) at 0, an edge of the polarity set by offset 0x14 (1 = rising, 0 = falling) sets the raw status bit. The bit stays set until it is cleared.
- R7: With the sense bit at 0 and the both-edges bit at 1, raw status latches on either edge and the polarity bit is ignored.
- R8: Masked status (offset 0x20) equals raw status ANDed with the enable register (offset 0x18). `irq` is 1 exactly when any masked bit is 1.
- R9: Writing 1 to a bit of the clear register (offset 0x24) clears that pin's latched edge status. Writing 0 has no effect. The clear register reads 0.
- R10: In level mode, a clear write does not remove a level that is still present.
- R11: A pin whose input-enable bit or mask bit is 0 causes no raw status in any mode.
- R12: A pad change becomes visible in the data register after exactly two clock edges. A latched edge appears in raw status one edge later.
- R13: Bits 31:16 of every register read 0, and offsets above 0x28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 7 | Byte address within the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong latched edge bit stays visible. It shows in raw status on the first read after the third clock edge following the pad change. It remains there until a clear, so a stuck or missing latch is seen within four cycles of the stimulus. A wrong polarity, sense or both-edges decode shows at the ports as a raw or masked bit that disagrees with the arithmetic expectation in the same sweep step. A slip in the synchronizer depth moves the data-register change one cycle earlier or later, and the bench samples exactly at the two-edge boundary.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] W_DAT  = IW'(0);
  localparam logic [IW-1:0] W_MSK  = IW'(1);
  localparam logic [IW-1:0] W_DIR  = IW'(2);
  localparam logic [IW-1:0] W_SNS  = IW'(3);
  localparam logic [IW-1:0] W_BOTH = IW'(4);
  localparam logic [IW-1:0] W_POL  = IW'(5);
  localparam logic [IW-1:0] W_IEN  = IW'(6);
  localparam logic [IW-1:0] W_RAW  = IW'(7);
  localparam logic [IW-1:0] W_MIS  = IW'(8);
  localparam logic [IW-1:0] W_CLR  = IW'(9);
  localparam logic [IW-1:0] W_INEN = IW'(10);

  logic [NPIN-1:0] dat_q, msk_q, dir_q, sns_q, both_q, pol_q, ien_q, inen_q;
  logic [NPIN-1:0] sy1_q, sy2_q, prv_q, edge_q;
  logic [NPIN-1:0] wd, qual_hi, qual_lo, rise, fall, evt, clr_hit, raw, mis;
  logic [IW-1:0]   idx;
  logic            unused_bits;

  assign idx = bus_addr[ADDR_W-1:2];
  assign wd  = bus_wdata[NPIN-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NPIN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      msk_q  <= '0;
      dir_q  <= '0;
      sns_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      inen_q <= '0;
    end else if (bus_wr) begin
      case (idx)
        W_DAT:  dat_q  <= (dat_q & ~msk_q) | (wd & msk_q);
        W_MSK:  msk_q  <= wd;
        W_DIR:  dir_q  <= wd;
        W_SNS:  sns_q  <= wd;
        W_BOTH: both_q <= wd;
        W_POL:  pol_q  <= wd;
        W_IEN:  ien_q  <= wd;
        W_INEN: inen_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      prv_q <= '0;
    end else begin
      sy1_q <= pad_in;
      sy2_q <= sy1_q;
      prv_q <= qual_hi;
    end
  end

  assign qual_hi = sy2_q & inen_q & msk_q;
  assign qual_lo = ~sy2_q & inen_q & msk_q;
  assign rise    = qual_hi & ~prv_q;
  assign fall    = prv_q & ~qual_hi;
  assign evt     = ~sns_q & ((both_q & (rise | fall)) |
                             (~both_q & pol_q & rise) |
                             (~both_q & ~pol_q & fall));
  assign clr_hit = (bus_wr && idx == W_CLR) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= '0;
    else        edge_q <= (edge_q & ~clr_hit) | evt;
  end

  assign raw     = (sns_q & ((pol_q & qual_hi) | (~pol_q & qual_lo))) | (~sns_q & edge_q);
  assign mis     = raw & ien_q;
  assign irq     = |mis;
  assign pad_oe  = dir_q & msk_q;
  assign pad_out = dat_q & pad_oe;

  always_comb begin
    bus_rdata = '0;
    case (idx)
      W_DAT:  bus_rdata[NPIN-1:0] = msk_q & ((dir_q & dat_q) | (~dir_q & sy2_q & inen_q));
      W_MSK:  bus_rdata[NPIN-1:0] = msk_q;
      W_DIR:  bus_rdata[NPIN-1:0] = dir_q;
      W_SNS:  bus_rdata[NPIN-1:0] = sns_q;
      W_BOTH: bus_rdata[NPIN-1:0] = both_q;
      W_POL:  bus_rdata[NPIN-1:0] = pol_q;
      W_IEN:  bus_rdata[NPIN-1:0] = ien_q;
      W_RAW:  bus_rdata[NPIN-1:0] = raw;
      W_MIS:  bus_rdata[NPIN-1:0] = mis;
      W_INEN: bus_rdata[NPIN-1:0] = inen_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   wd_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPIN-1:0]   pad_oe,
  input logic              irq,
  input logic [NPIN-1:0]   msk_q,
  input logic [NPIN-1:0]   ien_q,
  input logic [NPIN-1:0]   dat_q,
  input logic [NPIN-1:0]   edge_q
);
  localparam int IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  AST_MASK_OFF_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IW'(1) && wd_lo == '0) |=> (pad_oe == '0)); // R2
  AST_DATA_KEEPS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IW'(0)) |=> (((dat_q ^ $past(dat_q)) & ~$past(msk_q)) == '0)); // R3
  AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && idx == IW'(9)) |=> ((edge_q & $past(edge_q)) == $past(edge_q))); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0)); // R8
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IW'(9)) |-> (bus_rdata == '0)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > IW'(10)) |-> (bus_rdata == '0)); // R13
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_lo(bus_wdata[NPIN-1:0]), .bus_rdata(bus_rdata), .pad_oe(pad_oe), .irq(irq),
  .msk_q(msk_q), .ien_q(ien_q), .dat_q(dat_q), .edge_q(edge_q)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v, er0, er1, er2;
    logic [15:0] pb;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    for (int k = 0; k < 11; k++) begin
      rd(7'(4 * k), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset pad_oe", {16'h0, pad_oe}, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 output enable
    wr(7'h04, 32'h0FF0);
    wr(7'h08, 32'hA5A5);
    chk("R2 pad_oe", {16'h0, pad_oe}, 32'h05A0);
    // R3 masked data write
    wr(7'h00, 32'hFFFF);
    chk("R2 pad_out", {16'h0, pad_out}, 32'h05A0);
    wr(7'h04, 32'hFFFF);
    wr(7'h08, 32'hFFFF);
    rd(7'h00, v);
    chk("R3 unmasked bits kept", v, 32'h0FF0);
    wr(7'h00, 32'h0000_1234);
    rd(7'h00, v);
    chk("R3 full mask write", v, 32'h1234);
    chk("R2 pad_out follows data", {16'h0, pad_out}, 32'h1234);

    // R13 upper bits and unmapped offsets
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, v);
    chk("R13 upper bits zero", v, 32'h0000_FFFF);
    rd(7'h2C, v);
    chk("R13 offset 0x2C", v, 32'h0);
    rd(7'h7C, v);
    chk("R13 offset 0x7C", v, 32'h0);

    // R4 and R12 input read path
    wr(7'h08, 32'h0);
    wr(7'h28, 32'hFFFF);
    @(negedge clk); pad_in = 16'h3C3C;
    @(negedge clk);
    rd(7'h00, v);
    chk("R12 one edge not yet visible", v, 32'h0);
    @(negedge clk);
    rd(7'h00, v);
    chk("R12 visible after two edges", v, 32'h3C3C);
    wr(7'h08, 32'h00FF);
    wr(7'h00, 32'h0);
    rd(7'h00, v);
    chk("R4 mixed direction read", v, 32'h3C00);
    wr(7'h08, 32'h0);
    wr(7'h28, 32'hF0FF);
    rd(7'h00, v);
    chk("R4 input enable gates read", v, 32'h303C);
    wr(7'h04, 32'hFF0F);
    rd(7'h00, v);
    chk("R4 mask gates read", v, 32'h300C);

    // R11 gated pin cannot interrupt
    wr(7'h04, 32'hFFEF);
    wr(7'h28, 32'hFFF7);
    wr(7'h0C, 32'h0);
    wr(7'h10, 32'hFFFF);
    wr(7'h18, 32'hFFFF);
    @(negedge clk); pad_in = 16'h0;
    cyc(3);
    wr(7'h24, 32'hFFFF);
    @(negedge clk); pad_in = 16'h0018;
    cyc(3);
    rd(7'h1C, v);
    chk("R11 gated pins no edge", v, 32'h0);
    wr(7'h0C, 32'hFFFF);
    wr(7'h14, 32'h0);
    rd(7'h1C, v);
    chk("R11 gated pins no low level", v & 32'h18, 32'h0);
    chk("R11 irq from others only", {31'h0, irq}, 32'h1);
    @(negedge clk); pad_in = 16'h0;

    // Sweep: every pin, every trigger mode
    wr(7'h04, 32'hFFFF);
    wr(7'h28, 32'hFFFF);
    wr(7'h08, 32'h0);
    cyc(3);
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 5; m++) begin
        // m: 0 level high, 1 level low, 2 rising, 3 falling, 4 both edges
        pb = 16'(1 << p);
        wr(7'h18, {16'h0, pb});
        wr(7'h0C, (m < 2) ? 32'hFFFF : 32'h0);
        wr(7'h10, (m == 4) ? 32'hFFFF : 32'h0);
        wr(7'h14, (m == 0 || m == 2 || m == 4) ? 32'hFFFF : ((m == 1) ? 32'h0 : 32'h0));
        if (m == 4) wr(7'h14, 32'h0);
        wr(7'h24, 32'hFFFF);
        case (m)
          0: begin er0 = 0;       er1 = {16'h0, pb};        er2 = 0; end
          1: begin er0 = 32'hFFFF; er1 = 32'hFFFF & ~{16'h0, pb}; er2 = 32'hFFFF; end
          2: begin er0 = 0;       er1 = {16'h0, pb};        er2 = {16'h0, pb}; end
          3: begin er0 = 0;       er1 = 0;                  er2 = {16'h0, pb}; end
          default: begin er0 = 0; er1 = {16'h0, pb};        er2 = {16'h0, pb}; end
        endcase
        rd(7'h1C, v);
        chk((m < 2) ? "R5 idle raw" : "R6 idle raw", v, er0);
        @(negedge clk); pad_in = pb;
        cyc(3);
        rd(7'h1C, v);
        chk((m < 2) ? "R5 raw after rise" : ((m == 4) ? "R7 raw after rise" : "R6 raw after rise"), v, er1);
        rd(7'h20, v);
        chk("R8 masked after rise", v, er1 & {16'h0, pb});
        chk("R8 irq after rise", {31'h0, irq}, {31'h0, |(er1 & {16'h0, pb})});
        @(negedge clk); pad_in = 16'h0;
        cyc(3);
        rd(7'h1C, v);
        chk((m < 2) ? "R5 raw after fall" : ((m == 4) ? "R7 raw after fall" : "R6 raw after fall"), v, er2);
        wr(7'h24, 32'h0);
        rd(7'h1C, v);
        chk("R9 zero clear no effect", v, er2);
        rd(7'h24, v);
        chk("R9 clear reads zero", v, 32'h0);
        wr(7'h24, {16'h0, pb});
        rd(7'h1C, v);
        chk((m == 1) ? "R10 level survives clear" : "R9 clear removes edge", v,
            (m == 1) ? 32'hFFFF : 32'h0);
        chk("R8 irq after clear", {31'h0, irq}, (m == 1) ? 32'h1 : 32'h0);
      end
    end
    finish_up();
  end
endmodule